// File: doc/BRIEF.md
# Prioritized External Chip-Select Decoder

This block decodes a 24-bit bus address into four chip-select pins for an external memory port. Each select has its own window, with a base address given in 4 KB units, a window size from 256 bytes to 16 MB as a power of two, an enable bit and an active level. A small write port loads these settings. On every cycle the block compares the current address against every live window. It then picks one winner by a fixed ranking and drives the pins one clock later.

An internal-memory hit input beats every external window. Among the external windows, select 0 ranks highest and select 3 lowest. A global pin mode lets the lower pins carry upper address bits instead of selects. This lets a wider external memory or an outside decoder use those pins. A select whose pin is taken for an address bit does not decode at all. Pins that are not asserted always sit at their select's inactive level.

Top module: `ext_cs_decoder`

## Requirements
- R1: After reset, all four pins are high. Every select starts disabled and active-low, and nothing asserts until the block is enabled and configured.
- R2: The base of select n is written as address bits [23:12] on `cfgBase`, so every base lies on a 4 KB boundary. The value written takes effect on the cycle after the write strobe.
- R3: The size code k on `cfgSizeLog` makes a window of 2^k bytes, and address bits [23:k] are compared. Codes below 8 count as 8 and codes above 24 count as 24, where a code of 24 covers the whole space.
- R4: Base bits below k are ignored. A base that is not aligned to its window size is masked, not rejected.
- R5: If several windows match, the lowest select index wins. At most one select pin is asserted in any cycle.
- R6: When `intHit` is high, no select pin asserts in the resulting cycle.
- R7: If the active-level bit is 1, the select is active-high (asserted = 1, idle = 0). If the bit is 0, the select is active-low (asserted = 0, idle = 1).
- R8: `pinMode` sets the pin use as follows, and pin i, when given to an address, carries address bit 16+i.
  - 0: all four pins are selects.
  - 1: pins 3..1 are selects and pin 0 carries A16.
  - 2: pins 3..2 are selects and pins 1..0 carry A17/A16.
  - 3: all four pins carry A19..A16.
- R9: The pins are registered. The result for the inputs present at a rising edge appears right after that edge.
- R10: A disabled select never asserts and does not block a lower-ranked select that matches. The same holds for a select whose pin is given to an address bit.
- R11: While `blkEn` is low, every pin drives the inactive level of its select, whatever the mode.
- R12: While `addrValid` is low, no select pin asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write strobe for one select's settings |
| cfgIdx | input | 2 | Index of the select being written |
| cfgBase | input | 12 | Base address bits [23:12] |
| cfgSizeLog | input | 5 | log2 of window size in bytes |
| cfgEn | input | 1 | Select enable |
| cfgActHigh | input | 1 | 1 for an active-high select |
| blkEn | input | 1 | Global block enable |
| pinMode | input | 2 | Pin sharing mode |
| addrValid | input | 1 | Bus address is valid this cycle |
| intHit | input | 1 | Address hits internal memory |
| busAddr | input | 24 | Bus byte address |
| csPin | output | 4 | Select or address pins, bit i is pin i |

## Verification
A configuration write takes effect on the edge that samples the strobe, so an address driven on the following falling edge already sees the new window. Each address, valid, internal-hit, enable or mode change shows up on `csPin` exactly one rising edge after it is driven. The driver sets inputs on the falling edge and queues the expected pin value. The monitor pops that value and compares it 1 ns after the next rising edge. No check samples the pins in the same cycle the stimulus is applied, or two cycles later.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int NUM_CS = 4;
  localparam int MODE_W = 2;

  typedef struct packed {
    logic              blkOn;
    logic [NUM_CS-1:0] pinIsSel;
    logic [NUM_CS-1:0] selLive;
    logic [NUM_CS-1:0] actHigh;
  } csStrobe_t;
endpackage

// File: rtl/csdec_ctrl.sv
module csdec_ctrl
  import csdec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ALIGN_LOG = 12,
  parameter int MIN_LOG   = 8,
  localparam int BASE_W   = ADDR_W - ALIGN_LOG,
  localparam int SIZE_W   = $clog2(ADDR_W + 1),
  localparam int IDX_W    = $clog2(NUM_CS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWe,
  input  logic [IDX_W-1:0]               cfgIdx,
  input  logic [BASE_W-1:0]              cfgBase,
  input  logic [SIZE_W-1:0]              cfgSizeLog,
  input  logic                           cfgEn,
  input  logic                           cfgActHigh,
  input  logic                           blkEn,
  input  logic [MODE_W-1:0]              pinMode,
  output csStrobe_t                      strobes,
  output logic [NUM_CS-1:0][BASE_W-1:0]  baseArr,
  output logic [NUM_CS-1:0][SIZE_W-1:0]  sizeArr
);
  logic [NUM_CS-1:0][BASE_W-1:0] baseQ;
  logic [NUM_CS-1:0][SIZE_W-1:0] sizeQ;
  logic [NUM_CS-1:0]             enQ;
  logic [NUM_CS-1:0]             ahQ;
  logic [NUM_CS-1:0]             pinIsSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      sizeQ <= SIZE_W'(MIN_LOG);
      enQ   <= '0;
      ahQ   <= '0;
    end else if (cfgWe) begin
      baseQ[cfgIdx] <= cfgBase;
      sizeQ[cfgIdx] <= cfgSizeLog;
      enQ[cfgIdx]   <= cfgEn;
      ahQ[cfgIdx]   <= cfgActHigh;
    end
  end

  // Pin sharing: pins given to address bits are taken from the low end.
  always_comb begin
    case (pinMode)
      2'd0:    pinIsSel = 4'b1111;
      2'd1:    pinIsSel = 4'b1110;
      2'd2:    pinIsSel = 4'b1100;
      default: pinIsSel = 4'b0000;
    endcase
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_clamp
    always_comb begin
      if (sizeQ[i] < SIZE_W'(MIN_LOG))      sizeArr[i] = SIZE_W'(MIN_LOG);
      else if (sizeQ[i] > SIZE_W'(ADDR_W))  sizeArr[i] = SIZE_W'(ADDR_W);
      else                                  sizeArr[i] = sizeQ[i];
    end
  end

  assign baseArr          = baseQ;
  assign strobes.blkOn    = blkEn;
  assign strobes.pinIsSel = pinIsSel;
  assign strobes.selLive  = enQ & pinIsSel & {NUM_CS{blkEn}};
  assign strobes.actHigh  = ahQ;
endmodule

// File: rtl/csdec_datapath.sv
module csdec_datapath
  import csdec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ALIGN_LOG = 12,
  parameter int PIN_LSB   = 16,
  localparam int BASE_W   = ADDR_W - ALIGN_LOG,
  localparam int SIZE_W   = $clog2(ADDR_W + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  csStrobe_t                      strobes,
  input  logic [NUM_CS-1:0][BASE_W-1:0]  baseArr,
  input  logic [NUM_CS-1:0][SIZE_W-1:0]  sizeArr,
  input  logic                           addrValid,
  input  logic                           intHit,
  input  logic [ADDR_W-1:0]              busAddr,
  output logic [NUM_CS-1:0]              csPin
);
  logic [NUM_CS-1:0] hit;
  logic [NUM_CS-1:0] grant;
  logic [NUM_CS-1:0] pinNext;
  logic              claimed;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] fullBase;
    assign mask     = {ADDR_W{1'b1}} << sizeArr[i];
    assign fullBase = {baseArr[i], {ALIGN_LOG{1'b0}}};
    assign hit[i]   = strobes.selLive[i] && (((busAddr ^ fullBase) & mask) == '0);
  end

  // Fixed ranking: internal memory, then select 0 down to select 3.
  always_comb begin
    grant   = '0;
    claimed = intHit || !addrValid || !strobes.blkOn;
    for (int i = 0; i < NUM_CS; i++) begin
      if (!claimed && hit[i]) begin
        grant[i] = 1'b1;
        claimed  = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
    always_comb begin
      if (!strobes.blkOn)            pinNext[i] = ~strobes.actHigh[i];
      else if (!strobes.pinIsSel[i]) pinNext[i] = busAddr[PIN_LSB + i];
      else                           pinNext[i] = grant[i] ? strobes.actHigh[i] : ~strobes.actHigh[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPin <= '1;
    else       csPin <= pinNext;
  end

  // R5: at most one select pin asserted.
  a_r5_single_select: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $onehot0((csPin ~^ $past(strobes.actHigh)) &
                      $past(strobes.pinIsSel & {NUM_CS{strobes.blkOn}})));

  // R6: internal hit silences every select pin.
  a_r6_internal_wins: assert property (@(posedge clk) disable iff (!rstN)
    (intHit && strobes.blkOn) |=>
      (((csPin ^ ~$past(strobes.actHigh)) & $past(strobes.pinIsSel)) == '0));

  // R12: no valid address, no select.
  a_r12_invalid_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!addrValid && strobes.blkOn) |=>
      (((csPin ^ ~$past(strobes.actHigh)) & $past(strobes.pinIsSel)) == '0));

  // R11: disabled block drives inactive levels on every pin.
  a_r11_block_off: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.blkOn |=> (csPin == ~$past(strobes.actHigh)));

  // R8: a shared pin 0 follows the low shared address bit.
  a_r8_pin0_addr: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.blkOn && !strobes.pinIsSel[0]) |=> (csPin[0] == $past(busAddr[PIN_LSB])));

  // R10: a select that is not live never asserts.
  a_r10_dead_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.blkOn && strobes.pinIsSel[1] && !strobes.selLive[1]) |=>
      (csPin[1] == ~$past(strobes.actHigh[1])));
endmodule

// File: rtl/ext_cs_decoder.sv
module ext_cs_decoder
  import csdec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ALIGN_LOG = 12,
  parameter int MIN_LOG   = 8,
  parameter int PIN_LSB   = 16,
  localparam int BASE_W   = ADDR_W - ALIGN_LOG,
  localparam int SIZE_W   = $clog2(ADDR_W + 1),
  localparam int IDX_W    = $clog2(NUM_CS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [BASE_W-1:0]  cfgBase,
  input  logic [SIZE_W-1:0]  cfgSizeLog,
  input  logic               cfgEn,
  input  logic               cfgActHigh,
  input  logic               blkEn,
  input  logic [MODE_W-1:0]  pinMode,
  input  logic               addrValid,
  input  logic               intHit,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic [NUM_CS-1:0]  csPin
);
  csStrobe_t                     strobes;
  logic [NUM_CS-1:0][BASE_W-1:0] baseArr;
  logic [NUM_CS-1:0][SIZE_W-1:0] sizeArr;

  csdec_ctrl #(.ADDR_W(ADDR_W), .ALIGN_LOG(ALIGN_LOG), .MIN_LOG(MIN_LOG)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgBase(cfgBase),
    .cfgSizeLog(cfgSizeLog), .cfgEn(cfgEn), .cfgActHigh(cfgActHigh),
    .blkEn(blkEn), .pinMode(pinMode), .strobes(strobes),
    .baseArr(baseArr), .sizeArr(sizeArr)
  );

  csdec_datapath #(.ADDR_W(ADDR_W), .ALIGN_LOG(ALIGN_LOG), .PIN_LSB(PIN_LSB)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .baseArr(baseArr), .sizeArr(sizeArr),
    .addrValid(addrValid), .intHit(intHit), .busAddr(busAddr), .csPin(csPin)
  );
endmodule

// File: tb/ext_cs_decoder_tb_top.sv
module ext_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [11:0] cfgBase = '0;
  logic [4:0]  cfgSizeLog = '0;
  logic        cfgEn = 1'b0;
  logic        cfgActHigh = 1'b0;
  logic        blkEn = 1'b0;
  logic [1:0]  pinMode = '0;
  logic        addrValid = 1'b0;
  logic        intHit = 1'b0;
  logic [23:0] busAddr = '0;
  logic [3:0]  csPin;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [3:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  ext_cs_decoder dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgBase(cfgBase),
    .cfgSizeLog(cfgSizeLog), .cfgEn(cfgEn), .cfgActHigh(cfgActHigh), .blkEn(blkEn),
    .pinMode(pinMode), .addrValid(addrValid), .intHit(intHit), .busAddr(busAddr),
    .csPin(csPin)
  );

  // Monitor: result due one rising edge after the driver's falling edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [3:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        total++;
        if (csPin !== e) begin
          bad++;
          $display("FAIL %s: csPin actual=%b expected=%b", t, csPin, e);
        end
      end
    end
  end

  task automatic wcfg(input logic [1:0] idx, input logic [11:0] base, input logic [4:0] sz,
                      input logic en, input logic ah);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgBase = base; cfgSizeLog = sz; cfgEn = en; cfgActHigh = ah;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic step(input logic [23:0] a, input logic v, input logic h,
                      input logic [3:0] e, input string tag);
    @(negedge clk);
    busAddr = a; addrValid = v; intHit = h;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic setMode(input logic en, input logic [1:0] m);
    @(negedge clk);
    blkEn = en; pinMode = m;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step(24'h100000, 1'b1, 1'b0, 4'b1111, "R1 reset idle");
    // select 0: 1 MB @0x100000; select 1: 16 KB @0x104000;
    // select 2: 256 B @0x200000 active-high; select 3: 8 MB @0x800000
    wcfg(2'd0, 12'h100, 5'd20, 1'b1, 1'b0);
    wcfg(2'd1, 12'h104, 5'd14, 1'b1, 1'b0);
    wcfg(2'd2, 12'h200, 5'd8,  1'b1, 1'b1);
    wcfg(2'd3, 12'h800, 5'd23, 1'b1, 1'b0);
    step(24'h100000, 1'b1, 1'b0, 4'b1011, "R11 block off idle levels");
    setMode(1'b1, 2'd0);
    step(24'h100000, 1'b1, 1'b0, 4'b1010, "R3 select0 hit");
    step(24'h104010, 1'b1, 1'b0, 4'b1010, "R5 overlap select0 wins");
    step(24'h200010, 1'b1, 1'b0, 4'b1111, "R7 active-high select2");
    step(24'h200100, 1'b1, 1'b0, 4'b1011, "R3 outside 256B window");
    step(24'hFFFFFF, 1'b1, 1'b0, 4'b0011, "R3 select3 top of space");
    step(24'h100000, 1'b1, 1'b1, 4'b1011, "R6 internal hit");
    step(24'h100000, 1'b0, 1'b0, 4'b1011, "R12 invalid address");
    step(24'h104010, 1'b1, 1'b0, 4'b1010, "R9 back to select0");
    wcfg(2'd3, 12'h845, 5'd23, 1'b1, 1'b0);
    step(24'h800000, 1'b1, 1'b0, 4'b0011, "R4 misaligned base masked");
    step(24'h7FFFFF, 1'b1, 1'b0, 4'b1011, "R4 below masked base");
    wcfg(2'd0, 12'h100, 5'd20, 1'b0, 1'b0);
    step(24'h104010, 1'b1, 1'b0, 4'b1001, "R10 disabled select0 yields");
    step(24'h100000, 1'b1, 1'b0, 4'b1011, "R10 disabled select0 quiet");
    step(24'h103FFF, 1'b1, 1'b0, 4'b1011, "R2 below select1 base");
    step(24'h104000, 1'b1, 1'b0, 4'b1001, "R2 select1 base edge");
    step(24'h107FFF, 1'b1, 1'b0, 4'b1001, "R2 select1 last byte");
    step(24'h108000, 1'b1, 1'b0, 4'b1011, "R2 past select1");
    wcfg(2'd0, 12'h100, 5'd20, 1'b1, 1'b0);
    setMode(1'b1, 2'd1);
    step(24'h104010, 1'b1, 1'b0, 4'b1000, "R8 mode1 shared pin0 skips select0");
    step(24'h210000, 1'b1, 1'b0, 4'b1011, "R8 mode1 A16 high");
    setMode(1'b1, 2'd2);
    step(24'h230000, 1'b1, 1'b0, 4'b1011, "R8 mode2 A17 A16");
    step(24'h200020, 1'b1, 1'b0, 4'b1100, "R8 mode2 select2");
    setMode(1'b1, 2'd3);
    step(24'hA50000, 1'b1, 1'b0, 4'b0101, "R8 mode3 A19..A16 a");
    step(24'h0A0000, 1'b1, 1'b1, 4'b1010, "R8 mode3 A19..A16 b");
    setMode(1'b0, 2'd3);
    step(24'hA50000, 1'b1, 1'b0, 4'b1011, "R11 block off in mode3");
    setMode(1'b1, 2'd0);
    wcfg(2'd2, 12'h200, 5'd2, 1'b1, 1'b1);
    step(24'h200080, 1'b1, 1'b0, 4'b1111, "R3 small code clamps to 256B");
    step(24'h200100, 1'b1, 1'b0, 4'b1011, "R3 clamped window end");
    wcfg(2'd3, 12'h845, 5'd30, 1'b1, 1'b0);
    step(24'h300000, 1'b1, 1'b0, 4'b0011, "R3 large code covers space");
    step(24'h100000, 1'b1, 1'b0, 4'b1010, "R5 select0 beats full-space select3");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule